// File: doc/BRIEF.md
# Shared-Direction Host Command Queue

This block sits between an 8-bit host bus and the command processor of a display controller. The host sees two addresses, chosen by the select line `host_a0`. A write with `host_a0` high queues a command byte, and a write with `host_a0` low queues a parameter byte. A read with `host_a0` low returns the status byte, and a read with `host_a0` high returns read-back data. One ring of `DEPTH` entries (16 by default) carries bytes in only one direction at a time. In write mode it holds host bytes for the command processor. In read mode it holds result bytes for the host.

Each queued host byte carries a tag that marks it as a command or a parameter. The command processor uses the tag to find where a new operation starts: a command byte ends any earlier operation, even one whose parameter list is incomplete. The command processor pops tagged entries while the block is in write mode. For a read-type command, it turns the queue around. Everything still queued is dropped, and the processor then pushes result bytes for the host. Any command byte from the host turns the queue back to write mode and drops unread results. When the host and the command processor touch the ring in the same cycle, the host wins.

Top module: `hdx_cmd_fifo`

## Requirements
- R1: After a synchronous active-low reset the ring is empty and in write mode. The status byte reads 8'h04 and `cp_valid` is 0.
- R2: A host write with `host_a0`=1 queues the byte with tag 1 (command). A host write with `host_a0`=0 queues it with tag 0 (parameter). In write mode, `cp_valid`, `cp_data` and `cp_is_cmd` present the oldest entry, and `cp_pop` removes it in arrival order.
- R3: The ring holds `DEPTH` entries. When it holds `DEPTH` entries the full bit is set, and any host write is ignored.
- R4: A host read with `host_a0`=0 returns the status byte at any time and has no side effect. The byte layout is: bit 2 = empty, bit 1 = full, bit 0 = data ready, bits 7:3 = 0.
- R5: When the ring is in write mode, `cp_turn_read` drops every queued entry and puts the ring in read mode. In read mode, `cp_valid` is 0, and `cp_push` queues `cp_push_data` in order for the host.
- R6: Data ready is 1 in read mode while the ring is not empty. A host read with `host_a0`=1 while data ready is 1 pops the oldest byte into the host data register. From the next cycle that register drives `host_rdata` whenever `host_a0`=1.
- R7: A host data read while data ready is 0 pops nothing and leaves the host data register unchanged.
- R8: A command write in read mode drops all unread bytes, returns the ring to write mode, and leaves that command as the only entry.
- R9: A parameter write in read mode is ignored. A `cp_push` in write mode and a `cp_pop` in read mode are also ignored.
- R10: In a cycle with a host ring access (any write, or a read with `host_a0`=1), `cp_stall` is 1 and every request from the command processor is dropped for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_a0 | input | 1 | Address select: 1 = command write / data read, 0 = parameter write / status read |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte (`host_a0`=0) or host data register (`host_a0`=1) |
| cp_valid | output | 1 | Oldest entry available to the command processor |
| cp_data | output | 8 | Data of the oldest entry |
| cp_is_cmd | output | 1 | Tag of the oldest entry, 1 = command |
| cp_pop | input | 1 | Remove the oldest entry (write mode) |
| cp_push | input | 1 | Queue a result byte (read mode) |
| cp_push_data | input | 8 | Result byte |
| cp_turn_read | input | 1 | Drop queued entries and enter read mode |
| cp_stall | output | 1 | Host owns the ring this cycle; the request is dropped |

## Verification
Status, `cp_valid`, `cp_data` and `cp_is_cmd` change on the clock edge that takes an operation. They are due one cycle after that operation is driven. `host_rdata` and `cp_stall` are combinational in `host_a0` and the strobes, so they are due in the same cycle as the inputs that select them. A popped data byte appears on `host_rdata` one cycle after the read strobe. The bench drives every input at the falling edge and compares the same-cycle outputs 1 time unit later, before the next rising edge. A reference queue in the bench is then advanced at the rising edge, so registered results are compared on the following cycle.

// File: rtl/hdx_pkg.sv
// Shared types for the shared-direction host command queue.
// Assumes an 8-bit host byte and a 1-bit command/parameter tag.
package hdx_pkg;
    typedef enum logic {
        DIR_WR = 1'b0,
        DIR_RD = 1'b1
    } dir_e;

    typedef struct packed {
        logic       is_cmd;
        logic [7:0] data;
    } entry_t;

    localparam int ST_EMPTY = 2;
    localparam int ST_FULL  = 1;
    localparam int ST_READY = 0;
endpackage

// File: rtl/hdx_ring.sv
// Circular store of tagged entries with push, pop and flush.
// Assumes flush and push may coincide (the pushed entry becomes the sole entry)
// and that the caller never pushes when full or pops when empty.
module hdx_ring #(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  hdx_pkg::entry_t  push_entry,
    input  logic             pop_en,
    input  logic             flush,
    output hdx_pkg::entry_t  head,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    hdx_pkg::entry_t mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Entry storage: write the pushed entry at slot 0 on flush, else at wr_ptr.
    always_ff @(posedge clk) begin
        if (push_en) begin
            if (flush) mem[0] <= push_entry;
            else       mem[wr_ptr] <= push_entry;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= push_en ? AW'(1) : '0;
            count  <= push_en ? (AW+1)'(1) : '0;
        end else begin
            if (push_en) wr_ptr <= bump(wr_ptr);
            if (pop_en)  rd_ptr <= bump(rd_ptr);
            if (push_en && !pop_en)      count <= count + 1'b1;
            else if (pop_en && !push_en) count <= count - 1'b1;
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/hdx_ctrl.sv
// Arbitration and direction control. Picks one ring operation per cycle:
// the host first, then the command processor (turn > pop > push).
// Assumes full and empty come from the ring's current occupancy.
module hdx_ctrl (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic            host_rd,
    input  logic            host_a0,
    input  logic [7:0]      host_wdata,
    input  logic            cp_pop,
    input  logic            cp_push,
    input  logic [7:0]      cp_push_data,
    input  logic            cp_turn_read,
    input  logic            full,
    input  logic            empty,
    output hdx_pkg::dir_e   dir,
    output logic            push_en,
    output hdx_pkg::entry_t push_entry,
    output logic            pop_en,
    output logic            flush,
    output logic            load_rdata,
    output logic            cp_stall
);
    import hdx_pkg::*;

    dir_e dir_n;
    logic host_owns;

    assign host_owns = host_wr || (host_rd && host_a0);
    assign cp_stall  = host_owns;

    // Per-cycle decision of the single ring operation and next direction.
    always_comb begin
        dir_n      = dir;
        push_en    = 1'b0;
        pop_en     = 1'b0;
        flush      = 1'b0;
        load_rdata = 1'b0;
        push_entry = '{is_cmd: host_a0, data: host_wdata};
        if (host_wr) begin
            if (host_a0) begin
                if (dir == DIR_RD) begin
                    flush   = 1'b1;
                    push_en = 1'b1;
                    dir_n   = DIR_WR;
                end else if (!full) begin
                    push_en = 1'b1;
                end
            end else if (dir == DIR_WR && !full) begin
                push_en = 1'b1;
            end
        end else if (host_rd && host_a0) begin
            if (dir == DIR_RD && !empty) begin
                pop_en     = 1'b1;
                load_rdata = 1'b1;
            end
        end else if (cp_turn_read && dir == DIR_WR) begin
            flush = 1'b1;
            dir_n = DIR_RD;
        end else if (cp_pop && dir == DIR_WR && !empty) begin
            pop_en = 1'b1;
        end else if (cp_push && dir == DIR_RD && !full) begin
            push_en    = 1'b1;
            push_entry = '{is_cmd: 1'b0, data: cp_push_data};
        end
    end

    // Direction register.
    always_ff @(posedge clk) begin
        if (!rst_n) dir <= DIR_WR;
        else        dir <= dir_n;
    end
endmodule

// File: rtl/hdx_status.sv
// Builds the host status byte from the direction and the occupancy flags.
// Assumes the bit positions defined in hdx_pkg.
module hdx_status (
    input  hdx_pkg::dir_e dir,
    input  logic          empty,
    input  logic          full,
    output logic [7:0]    status
);
    import hdx_pkg::*;

    // Status byte assembly.
    always_comb begin
        status           = '0;
        status[ST_EMPTY] = empty;
        status[ST_FULL]  = full;
        status[ST_READY] = (dir == DIR_RD) && !empty;
    end
endmodule

// File: rtl/hdx_cmd_fifo.sv
// Top: host byte port plus command-processor port around one shared ring.
// Assumes one-cycle host strobes and DEPTH of at least 2.
module hdx_cmd_fifo #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_a0,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       cp_valid,
    output logic [7:0] cp_data,
    output logic       cp_is_cmd,
    input  logic       cp_pop,
    input  logic       cp_push,
    input  logic [7:0] cp_push_data,
    input  logic       cp_turn_read,
    output logic       cp_stall
);
    import hdx_pkg::*;

    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    dir_e          dir_q;
    entry_t        head;
    entry_t        push_entry;
    logic [CW-1:0] count;
    logic          push_en, pop_en, flush, load_rdata;
    logic          full, empty;
    logic [7:0]    status;
    logic [7:0]    rdata_q;

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);

    hdx_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_a0(host_a0),
        .host_wdata(host_wdata),
        .cp_pop(cp_pop), .cp_push(cp_push), .cp_push_data(cp_push_data),
        .cp_turn_read(cp_turn_read),
        .full(full), .empty(empty),
        .dir(dir_q), .push_en(push_en), .push_entry(push_entry),
        .pop_en(pop_en), .flush(flush), .load_rdata(load_rdata),
        .cp_stall(cp_stall)
    );

    hdx_ring #(.DEPTH(DEPTH)) ring_i (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_entry(push_entry),
        .pop_en(pop_en), .flush(flush),
        .head(head), .count(count)
    );

    hdx_status status_i (
        .dir(dir_q), .empty(empty), .full(full), .status(status)
    );

    // Host data register: takes the popped byte on a host data read.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_q <= '0;
        else if (load_rdata) rdata_q <= head.data;
    end

    assign host_rdata = host_a0 ? rdata_q : status;
    assign cp_valid   = (dir_q == DIR_WR) && !empty;
    assign cp_data    = head.data;
    assign cp_is_cmd  = head.is_cmd;
endmodule

// File: rtl/hdx_cmd_fifo_chk.sv
// Temporal checks on the shared-direction queue, attached by bind.
module hdx_cmd_fifo_chk #(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   host_wr,
    input logic                   host_rd,
    input logic                   host_a0,
    input logic                   cp_pop,
    input logic                   cp_turn_read,
    input logic                   cp_valid,
    input logic                   dir,
    input logic [$clog2(DEPTH):0] count,
    input logic [7:0]             rdata_q,
    input logic [7:0]             status
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    // R8
    cmd_forces_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_a0 |=> !dir && count != '0);

    // R3
    full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && !dir && count == FULL_CNT |=> $stable(count));

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R7
    noready_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_a0 && !status[0] && !host_wr |=> $stable(rdata_q));

    // R5
    turn_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_turn_read && !host_wr && !(host_rd && host_a0) && !dir
        |=> dir && count == '0);

    // R10
    stall_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_pop && cp_valid && host_rd && host_a0 && !host_wr |=> $stable(count));
endmodule

bind hdx_cmd_fifo hdx_cmd_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_a0(host_a0),
    .cp_pop(cp_pop), .cp_turn_read(cp_turn_read), .cp_valid(cp_valid),
    .dir(dir_q), .count(count), .rdata_q(rdata_q), .status(status)
);

// File: tb/hdx_cmd_fifo_tb.sv
module hdx_cmd_fifo_tb_top;
    localparam int CLK_P = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 0, host_rd = 0, host_a0 = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       cp_valid, cp_is_cmd, cp_stall;
    logic [7:0] cp_data;
    logic       cp_pop = 0, cp_push = 0, cp_turn_read = 0;
    logic [7:0] cp_push_data = 0;

    int nvec = 0;
    int nfail = 0;

    // Reference queue built from the requirements
    logic [7:0] m_data [DEPTH];
    logic       m_tag  [DEPTH];
    int         m_cnt = 0;
    logic       m_rd  = 0;
    logic [7:0] m_dreg = 0;

    always #(CLK_P/2) clk = ~clk;

    hdx_cmd_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_a0(host_a0),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cp_valid(cp_valid), .cp_data(cp_data), .cp_is_cmd(cp_is_cmd),
        .cp_pop(cp_pop), .cp_push(cp_push), .cp_push_data(cp_push_data),
        .cp_turn_read(cp_turn_read), .cp_stall(cp_stall)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {5'b0, m_cnt == 0, m_cnt == DEPTH, m_rd && m_cnt != 0};
    endfunction

    function automatic void m_shift();
        for (int i = 0; i < DEPTH - 1; i++) begin
            m_data[i] = m_data[i+1];
            m_tag[i]  = m_tag[i+1];
        end
        m_cnt--;
    endfunction

    function automatic void m_put(input logic tag, input logic [7:0] d);
        m_data[m_cnt] = d;
        m_tag[m_cnt]  = tag;
        m_cnt++;
    endfunction

    // Advance the reference queue by one clock edge, from the driven inputs
    function automatic void m_update();
        if (host_wr) begin
            if (host_a0) begin
                if (m_rd) begin m_cnt = 0; m_rd = 0; end
                if (m_cnt < DEPTH) m_put(1'b1, host_wdata);
            end else if (!m_rd && m_cnt < DEPTH) begin
                m_put(1'b0, host_wdata);
            end
        end else if (host_rd && host_a0) begin
            if (m_rd && m_cnt > 0) begin m_dreg = m_data[0]; m_shift(); end
        end else if (cp_turn_read && !m_rd) begin
            m_cnt = 0; m_rd = 1;
        end else if (cp_pop && !m_rd && m_cnt > 0) begin
            m_shift();
        end else if (cp_push && m_rd && m_cnt < DEPTH) begin
            m_put(1'b0, cp_push_data);
        end
    endfunction

    task automatic compare();
        logic hf;
        hf = host_wr || (host_rd && host_a0);
        if (host_a0) check("R6", {8'h0, host_rdata}, {8'h0, m_dreg});
        else         check("R4", {8'h0, host_rdata}, {8'h0, exp_status()});
        check("R2", {15'h0, cp_valid}, {15'h0, !m_rd && m_cnt != 0});
        if (!m_rd && m_cnt != 0)
            check("R2", {7'h0, cp_is_cmd, cp_data}, {7'h0, m_tag[0], m_data[0]});
        check("R10", {15'h0, cp_stall}, {15'h0, hf});
    endtask

    task automatic step(input logic wr, rd, a0, input logic [7:0] wd,
                        input logic pop, push, turn, input logic [7:0] pd);
        host_wr = wr; host_rd = rd; host_a0 = a0; host_wdata = wd;
        cp_pop = pop; cp_push = push; cp_turn_read = turn; cp_push_data = pd;
        #1;
        compare();
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    task automatic peek(input logic a0);
        host_wr = 0; host_rd = 0; cp_pop = 0; cp_push = 0; cp_turn_read = 0;
        host_a0 = a0;
        #1;
    endtask

    task automatic hwr(input logic a0, input logic [7:0] d);
        step(1, 0, a0, d, 0, 0, 0, 8'h0);
    endtask

    initial begin
        #(CLK_P * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek(0);
        check("R1", {8'h0, host_rdata}, 16'h0004);
        check("R1", {15'h0, cp_valid}, 16'h0);

        // R2: tagged entries in order
        hwr(1, 8'h3C); hwr(0, 8'h11); hwr(0, 8'h22);
        peek(0);
        check("R2", {7'h0, cp_is_cmd, cp_data}, 16'h013C);
        repeat (3) step(0, 0, 0, 0, 1, 0, 0, 0);

        // R3: fill to DEPTH, then an extra write is dropped
        hwr(1, 8'h80);
        for (int i = 1; i < DEPTH; i++) hwr(0, 8'(i));
        peek(0);
        check("R3", {8'h0, host_rdata}, 16'h0002);
        hwr(0, 8'hEE);
        hwr(1, 8'hEF);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1, 0, 0, 0);
        peek(0);
        check("R3", {8'h0, host_rdata}, 16'h0004);

        // R5: turnaround drops queued bytes, result bytes queue for host
        hwr(1, 8'h50); hwr(0, 8'h60); hwr(0, 8'h61);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        peek(0);
        check("R5", {8'h0, host_rdata}, 16'h0004);
        check("R5", {15'h0, cp_valid}, 16'h0);
        step(0, 0, 0, 0, 0, 1, 0, 8'hA1);
        step(0, 0, 0, 0, 0, 1, 0, 8'hA2);
        peek(0);
        check("R5", {8'h0, host_rdata}, 16'h0001);

        // R9: parameter write and consumer pop in read mode are ignored
        hwr(0, 8'h77);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        peek(0);
        check("R9", {8'h0, host_rdata}, 16'h0001);

        // R6: host data reads
        step(0, 1, 1, 0, 0, 0, 0, 0);
        peek(1);
        check("R6", {8'h0, host_rdata}, 16'h00A1);
        step(0, 1, 1, 0, 0, 0, 0, 0);
        peek(1);
        check("R6", {8'h0, host_rdata}, 16'h00A2);
        peek(0);
        check("R6", {8'h0, host_rdata}, 16'h0004);

        // R7: read with no data ready
        step(0, 1, 1, 0, 0, 0, 0, 0);
        peek(1);
        check("R7", {8'h0, host_rdata}, 16'h00A2);

        // R8: command write drops unread results
        step(0, 0, 0, 0, 0, 1, 0, 8'hB1);
        step(0, 0, 0, 0, 0, 1, 0, 8'hB2);
        hwr(1, 8'h0F);
        peek(0);
        check("R8", {8'h0, host_rdata}, 16'h0000);
        check("R8", {7'h0, cp_is_cmd, cp_data}, 16'h010F);

        // R9: push in write mode ignored; R10: host write beats consumer pop
        step(0, 0, 0, 0, 0, 1, 0, 8'hC3);
        step(1, 0, 0, 8'h44, 1, 0, 0, 0);
        peek(0);
        check("R10", {7'h0, cp_is_cmd, cp_data}, 16'h010F);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0);

        // Random mix against the reference queue
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom % 100;
            step(r < 22, r >= 22 && r < 45, 1'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom), ($urandom % 25) == 0, 8'($urandom));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule